// File: doc/BRIEF.md
# Switchable NRZ / Infrared Serial Line Coder

This block sits between a UART bit engine and the serial pins. The transmit side takes one bit at a time over a valid/ready stream and holds each bit on the line for one bit period of `OVERSAMPLE` sampling ticks. The receive side turns the line back into a level-coded bit stream for the receiver's sampler. A mode input selects the line format. In plain mode the bits go straight through as NRZ, and the line idles high. In infrared mode each zero bit is sent as a short high pulse in the middle of its bit period, a one bit sends nothing, and the line idles low.

On the transmit stream, a bit is taken on every clock edge where `tx_valid` and `tx_ready` are both high. The source may hold `tx_valid` for as long as it likes. Once raised, `tx_valid` and `tx_bit` must stay unchanged until the bit is taken. `tx_ready` goes high on the final tick of the current bit, so a source that keeps valid high gets bit periods with no gap between them. The receive output is a plain level with no handshake. In infrared mode each detected pulse is stretched into a low level slightly longer than one bit period, so runs of zeros decode as one unbroken low. A new mode request is applied only while no bit is on the line, so a pulse is never cut short.

Top module: `line_coder`

## Requirements
- R1: While `rst_n` is low, `tx_pin` is 1 and `rx_bit` is 1 whatever `rx_pin` does, and the active mode returns to plain (mode code 0).
- R2: `tx_ready` is high when no bit is in progress, or when a bit is in progress and `tick16` is high with the bit on its last tick (tick index `OVERSAMPLE-1`). A bit is taken when `tx_valid` and `tx_ready` are both high. Each bit lasts `OVERSAMPLE` ticks, counted from index 0 at acceptance.
- R3: In plain mode, `tx_pin` equals the current bit from the edge that accepts it until its period ends, and it is 1 when idle.
- R4: In infrared mode (mode code 1), a 0 bit drives `tx_pin` high while its tick index is in the range `OVERSAMPLE/2` to `OVERSAMPLE/2+PULSE_TICKS-1`, which is 3 ticks by default. A 1 bit drives no pulse. The pin is 0 at all other times, including idle.
- R5: The active mode takes the value of `ir_mode_sel` only on an edge where no bit is in progress and none is being accepted. Otherwise the previous mode stays in force.
- R6: In plain mode, `rx_bit` equals the value `rx_pin` had two clock cycles earlier (`SYNC_STAGES` = 2).
- R7: In infrared mode, a rising edge on the synchronised `rx_pin` drives `rx_bit` low for `OVERSAMPLE+SYNC_STAGES+1` ticks. A new edge restarts this count. With no edge, `rx_bit` is 1.
- R8: With `tx_pin` looped back to `rx_pin` in infrared mode, `rx_bit` sampled on the last tick of each transmitted bit equals that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle sampling tick at 16 times the bit rate |
| ir_mode_sel | input | 1 | Requested mode: 0 plain NRZ, 1 infrared pulse |
| tx_valid | input | 1 | Transmit bit offered |
| tx_ready | output | 1 | Coder takes the offered bit at this edge |
| tx_bit | input | 1 | Transmit bit value |
| tx_pin | output | 1 | Serial line output |
| rx_pin | input | 1 | Serial line input |
| rx_bit | output | 1 | Recovered receive bit level |

## Verification
The hardest case to reach is a mode request that arrives while a bit is still on the line. The request must wait, and the bit must finish in the old format. The stimulus flips `ir_mode_sel` right after a bit is accepted, and it also switches modes inside a back-to-back stream of random bits. A second hard case is a run of consecutive infrared zeros, which must decode as one low with no gaps between pulses. It is reached by looping `tx_pin` back to `rx_pin` while random bits and framed bytes stream without gaps. Hand-driven pulses on `rx_pin`, including a retrigger, check the length of the decoded low.

// File: rtl/line_coder_pkg.sv
package line_coder_pkg;
  typedef enum logic {
    LM_NRZ = 1'b0,
    LM_IR  = 1'b1
  } line_mode_e;
endpackage

// File: rtl/lc_mode_ctrl.sv
module lc_mode_ctrl
  import line_coder_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_req,
  input  logic       tx_idle,
  output line_mode_e mode_d,
  output line_mode_e mode_q
);
  // a request is only applied when no bit is on the line
  always_comb begin
    mode_d = mode_q;
    if (tx_idle) mode_d = mode_req ? LM_IR : LM_NRZ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= LM_NRZ;
    else        mode_q <= mode_d;
  end
endmodule

// File: rtl/lc_tx_encoder.sv
module lc_tx_encoder
  import line_coder_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int PULSE_TICKS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  line_mode_e mode_d,
  input  logic       tx_valid,
  input  logic       tx_bit,
  output logic       tx_ready,
  output logic       accept,
  output logic       busy_q,
  output logic       bit_q,
  output logic       tx_pin
);
  localparam int CW = $clog2(OVERSAMPLE);
  localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);
  localparam int P_START = OVERSAMPLE / 2;
  localparam int P_END   = P_START + PULSE_TICKS;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_d, bit_d, pin_d, last;

  always_comb begin
    last     = (cnt_q == LAST);
    tx_ready = !busy_q || (tick && last);
    accept   = tx_valid && tx_ready;
    busy_d   = busy_q;
    bit_d    = bit_q;
    cnt_d    = cnt_q;
    if (accept) begin
      busy_d = 1'b1;
      bit_d  = tx_bit;
      cnt_d  = '0;
    end else if (busy_q && tick) begin
      if (last) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  // pin is computed from the next state so it moves with the bit counter
  always_comb begin
    unique case (mode_d)
      LM_NRZ: pin_d = busy_d ? bit_d : 1'b1;
      LM_IR:  pin_d = busy_d && !bit_d &&
                      (int'(cnt_d) >= P_START) && (int'(cnt_d) < P_END);
      default: pin_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      bit_q  <= 1'b1;
      cnt_q  <= '0;
      tx_pin <= 1'b1;
    end else begin
      busy_q <= busy_d;
      bit_q  <= bit_d;
      cnt_q  <= cnt_d;
      tx_pin <= pin_d;
    end
  end
endmodule

// File: rtl/lc_rx_decoder.sv
module lc_rx_decoder
  import line_coder_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  line_mode_e mode_q,
  input  logic       rx_pin,
  output logic       rx_bit
);
  localparam int HOLD = OVERSAMPLE + SYNC_STAGES + 1;
  localparam int HW   = $clog2(HOLD + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q, line_s, rise;
  logic [HW-1:0]          hold_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b1;
        else if (i == 0) sync_q[i] <= rx_pin;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign line_s = sync_q[SYNC_STAGES-1];
  assign rise   = line_s && !prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      hold_q <= '0;
    end else begin
      prev_q <= line_s;
      if (mode_q != LM_IR)            hold_q <= '0;
      else if (rise)                  hold_q <= HW'(HOLD);
      else if (tick && hold_q != '0)  hold_q <= hold_q - 1'b1;
    end
  end

  assign rx_bit = (mode_q == LM_IR) ? (hold_q == '0) : line_s;
endmodule

// File: rtl/line_coder.sv
module line_coder
  import line_coder_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int PULSE_TICKS = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick16,
  input  logic ir_mode_sel,
  input  logic tx_valid,
  output logic tx_ready,
  input  logic tx_bit,
  output logic tx_pin,
  input  logic rx_pin,
  output logic rx_bit
);
  line_mode_e mode_d, mode_q;
  logic       tx_accept, tx_busy, tx_cur_bit, tx_idle;

  assign tx_idle = !tx_busy && !tx_accept;

  lc_mode_ctrl u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_req (ir_mode_sel),
    .tx_idle  (tx_idle),
    .mode_d   (mode_d),
    .mode_q   (mode_q)
  );

  lc_tx_encoder #(
    .OVERSAMPLE  (OVERSAMPLE),
    .PULSE_TICKS (PULSE_TICKS)
  ) u_enc (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick16),
    .mode_d   (mode_d),
    .tx_valid (tx_valid),
    .tx_bit   (tx_bit),
    .tx_ready (tx_ready),
    .accept   (tx_accept),
    .busy_q   (tx_busy),
    .bit_q    (tx_cur_bit),
    .tx_pin   (tx_pin)
  );

  lc_rx_decoder #(
    .OVERSAMPLE  (OVERSAMPLE),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick16),
    .mode_q (mode_q),
    .rx_pin (rx_pin),
    .rx_bit (rx_bit)
  );
endmodule

// File: rtl/lc_checker.sv
module lc_checker #(
  parameter int PULSE_TICKS = 3
) (
  input logic clk,
  input logic rst_n,
  input logic tick16,
  input logic tx_valid,
  input logic tx_ready,
  input logic tx_bit,
  input logic tx_pin,
  input logic rx_bit,
  input logic mode_ir,
  input logic busy_q,
  input logic bit_q
);
  logic [7:0] hi_ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 hi_ticks <= '0;
    else if (!tx_pin || !mode_ir) hi_ticks <= '0;
    else if (tick16)            hi_ticks <= hi_ticks + 8'd1;
  end

  // R1
  reset_line_idle_chk: assert property (@(posedge clk)
    !rst_n |-> tx_pin && rx_bit);

  // R2
  offer_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_bit));

  // R3
  nrz_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_ir && !busy_q |-> tx_pin);

  // R4
  ir_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ir && !busy_q |-> !tx_pin);

  // R4
  ir_pulse_zero_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ir && tx_pin |-> !bit_q);

  // R4
  ir_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(hi_ticks) <= PULSE_TICKS);

  // R5
  mode_switch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ir != $past(mode_ir) |-> $past(!busy_q && !(tx_valid && tx_ready)));
endmodule

bind line_coder lc_checker #(.PULSE_TICKS(PULSE_TICKS)) u_lc_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick16   (tick16),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .tx_bit   (tx_bit),
  .tx_pin   (tx_pin),
  .rx_bit   (rx_bit),
  .mode_ir  (mode_q == line_coder_pkg::LM_IR),
  .busy_q   (tx_busy),
  .bit_q    (tx_cur_bit)
);

// File: tb/test_line_coder.sv
module test_line_coder;
  localparam int OS = 16;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic tick16 = 1'b0;
  logic ir_mode_sel = 1'b1;
  logic tx_valid = 1'b0;
  logic tx_bit = 1'b1;
  logic rx_drv = 1'b0;
  logic loop_en = 1'b0;
  logic tx_ready, tx_pin, rx_bit, rx_pin;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  assign rx_pin = loop_en ? tx_pin : rx_drv;

  line_coder i_line_coder (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .ir_mode_sel(ir_mode_sel),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_bit(tx_bit),
    .tx_pin(tx_pin), .rx_pin(rx_pin), .rx_bit(rx_bit)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_ready(bit busy, int k, bit tk);
    return !busy || (tk && k == OS-1);
  endfunction

  function automatic bit exp_pin(bit ir, bit busy, bit b, int k);
    if (!ir) return busy ? b : 1'b1;
    return busy && !b && k >= OS/2 && k < OS/2 + PW;
  endfunction

  // tick generator: one cycle in four
  initial begin
    int div = 0;
    forever begin
      @(posedge clk); #1;
      div = (div + 1) % 4;
      tick16 = (div == 3);
    end
  end

  // reference model sampled at negedge, inputs change only just after posedge
  bit m_busy = 0, m_bit = 1, m_ir = 0;
  int m_k = 0, stable = 0;
  bit h0 = 1, h1 = 1;

  always @(negedge clk) begin
    cycles++;
    if (!rst_n) begin
      chk(tx_pin == 1'b1, "R1 tx_pin in reset", tx_pin, 1);
      chk(rx_bit == 1'b1, "R1 rx_bit in reset", rx_bit, 1);
      m_busy = 0; m_bit = 1; m_k = 0; m_ir = 0; stable = 0; h0 = 1; h1 = 1;
    end else begin
      bit er, ep, acc, nir;
      er = exp_ready(m_busy, m_k, tick16);
      chk(tx_ready == er, "R2 tx_ready", tx_ready, er);
      ep = exp_pin(m_ir, m_busy, m_bit, m_k);
      chk(tx_pin == ep, m_ir ? "R4 ir tx_pin" : "R3 nrz tx_pin", tx_pin, ep);
      if (!m_ir && stable >= 3)
        chk(rx_bit == h1, "R6 nrz rx_bit", rx_bit, h1);
      if (loop_en && m_ir && m_busy && tick16 && m_k == OS-1)
        chk(rx_bit == m_bit, "R8 loopback bit", rx_bit, m_bit);
      h1 = h0; h0 = rx_pin;
      acc = tx_valid && er;
      nir = m_ir;
      if (!m_busy && !acc) nir = ir_mode_sel;
      if (acc) begin
        m_busy = 1; m_bit = tx_bit; m_k = 0;
      end else if (m_busy && tick16) begin
        if (m_k == OS-1) begin m_busy = 0; m_k = 0; end
        else m_k++;
      end
      stable = (nir == m_ir) ? stable + 1 : 0;
      m_ir = nir;
    end
  end

  task automatic send_bit(input bit b);
    tx_valid = 1'b1;
    tx_bit = b;
    forever begin
      @(negedge clk);
      if (tx_ready) break;
    end
    @(posedge clk); #1;
  endtask

  task automatic send_random(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      send_bit(1'($urandom));
      if (gaps && ($urandom % 3 == 0)) begin
        tx_valid = 1'b0;
        repeat ($urandom % 40) @(posedge clk);
        #1;
      end
      if (!loop_en && ($urandom % 4 == 0)) rx_drv = 1'($urandom);
    end
    tx_valid = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    send_bit(1'b1);
    tx_valid = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (OS * 4 + 8) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0;
    repeat (5) @(posedge clk);
    #1;
    rst_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd4711));
    #1 rst_n = 1'b0;  // R1: reset with infrared requested and rx low
    repeat (6) @(posedge clk);
    #1;
    ir_mode_sel = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_pin == 1'b1, "R1 plain idle after reset", tx_pin, 1);
    @(posedge clk); #1;

    // plain mode, random bits with gaps and rx toggling (R3, R6)
    rx_drv = 1'b1;
    send_random(30, 1'b1);
    send_byte(8'hA5);

    // R5: request infrared just after a bit is taken
    send_bit(1'b1);
    tx_valid = 1'b0;
    ir_mode_sel = 1'b1;
    @(negedge clk);
    chk(tx_pin == 1'b1, "R5 mode deferred while busy", tx_pin, 1);
    wait_idle();
    chk(tx_pin == 1'b0, "R5 infrared idle after switch", tx_pin, 0);

    // infrared loopback: back-to-back and gapped random bits, bytes (R4, R8)
    loop_en = 1'b1;
    send_random(40, 1'b0);
    send_random(30, 1'b1);
    send_byte(8'h00);
    send_byte(8'h3C);
    send_byte(8'hFF);
    wait_idle();
    loop_en = 1'b0;
    rx_drv = 1'b0;
    wait_idle();

    // R7: a single pulse, then a retriggered pair
    chk(rx_bit == 1'b1, "R7 ir idle decode", rx_bit, 1);
    rx_drv = 1'b1; repeat (2) @(posedge clk); #1; rx_drv = 1'b0;
    repeat (38) @(posedge clk); #1;
    chk(rx_bit == 1'b0, "R7 decoded low held", rx_bit, 0);
    repeat (60) @(posedge clk); #1;
    chk(rx_bit == 1'b1, "R7 decoded low expired", rx_bit, 1);
    rx_drv = 1'b1; repeat (2) @(posedge clk); #1; rx_drv = 1'b0;
    repeat (48) @(posedge clk); #1;
    rx_drv = 1'b1; repeat (2) @(posedge clk); #1; rx_drv = 1'b0;
    repeat (58) @(posedge clk); #1;
    chk(rx_bit == 1'b0, "R7 retrigger extends low", rx_bit, 0);
    repeat (40) @(posedge clk); #1;
    chk(rx_bit == 1'b1, "R7 retrigger expired", rx_bit, 1);

    // switch back to plain inside a stream (R5, R3)
    loop_en = 1'b1;
    fork
      send_random(20, 1'b0);
      begin repeat (100) @(posedge clk); #1; ir_mode_sel = 1'b0; end
    join
    wait_idle();
    chk(tx_pin == 1'b1, "R3 plain idle high", tx_pin, 1);

    // R1: reset while an infrared bit is on the line
    ir_mode_sel = 1'b1;
    wait_idle();
    send_bit(1'b0);
    tx_valid = 1'b0;
    do_reset();
    @(negedge clk);
    chk(tx_pin == 1'b1, "R1 plain after mid-bit reset", tx_pin, 1);
    loop_en = 1'b0;
    ir_mode_sel = 1'b0;
    wait_idle();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cycles);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule